// File: doc/BRIEF.md
# Clause-22 MDIO Management Master

This block runs IEEE 802.3 clause-22 management frames toward a PHY over a two-wire serial management bus (MDC clock, bidirectional MDIO data). The host controls it with two 16-bit words. One is a data word; the other is a command word that packs the PHY address, the register offset and a write-select bit. Writing the command word launches one complete frame. A `done` flag reports the result. It is high while the block is idle, drops once a command is accepted and rises again when the frame has finished.

For a write, the host loads the data word first and then issues the command. The block sends the preamble, start, opcode, both address fields, a driven turnaround and the 16 data bits. For a read, the block releases MDIO after the register address. It samples 16 bits on rising MDC and places them in the data word on completion. An unpopulated address therefore reads back as all ones, because the bus idles high.

MDC is produced from the system clock by an even divider parameter. The frame length is fixed, so every transaction takes a known number of system cycles.

Top module: `mdio_master`

## Requirements
- R1: After reset, `done` is 1, `mdc` is 0, `mdio_oe` is 0 and `dat_rdata` is 0x0000.
- R2: Command word fields are: PHY address in bits 12:8, register offset in bits 4:0, and write select in bit 13 (1 = write, 0 = read). Each frame is 64 bit times long. It starts with 32 ones, then start bits 0,1, then opcode 0,1 for a write or 1,0 for a read, then the PHY address and the register offset, each MSB first.
- R3: In a write frame, bit times 46-47 carry turnaround 1,0 and bit times 48-63 carry the data word MSB first. `mdio_oe` stays 1 for all 64 bit times.
- R4: In a read frame, `mdio_oe` is 0 from bit time 46 to the end. MDIO is sampled on rising MDC during bit times 48-63, MSB first, and the 16-bit result appears on `dat_rdata` once `done` rises.
- R5: A read addressed to a PHY that never drives the line returns 0xFFFF.
- R6: MDC is 0 while idle. During a frame, each bit time is `DIV` system clocks, and MDC is high for the second half of it.
- R7: `done` is 0 in the cycle after the command write is accepted. It returns to 1 exactly 64*`DIV` clocks after the accepting edge.
- R8: While `done` is 0, command writes and data-word writes are ignored. The frame in flight and the data word are unchanged.
- R9: Command bits 15:14 and 7:5 have no effect on the frame.
- R10: MDIO output changes only while MDC is low: it is stable across every clock in which MDC stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word value |
| dat_we | input | 1 | Data word write strobe |
| dat_wdata | input | 16 | Data word value |
| dat_rdata | output | 16 | Data word (write data or last read result) |
| done | output | 1 | Command finished / idle flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value |

## Verification
The bench builds the block with `DIV` = 4, which makes each frame 256 clocks long. That keeps a full sweep affordable: a write to every one of the 32 PHY addresses, and a read from every address against a responder that answers on only one of them. The bench rebuilds each frame bit by bit from the command fields and compares it with the line seen at each rising MDC, including the output-enable pattern. It also reads several edge data patterns from the populated address, and it issues commands and data writes in the middle of a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  // Bit FRAME_BITS-1 goes out first.
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic        wr,
    input logic [4:0]  phy,
    input logic [4:0]  regad,
    input logic [15:0] wdata
  );
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] dv;
    op = wr ? 2'b01 : 2'b10;
    ta = wr ? 2'b10 : 2'b11;
    dv = wr ? wdata : 16'hFFFF;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regad, ta, dv};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic smp_stb,
  output logic end_stb
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign smp_stb = run && (cnt == CW'(HALF - 1));
  assign end_stb = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      if (end_stb) cnt <= '0;
      else         cnt <= cnt + 1'b1;
      if (smp_stb)      mdc <= 1'b1;
      else if (end_stb) mdc <= 1'b0;
    end
  end

  // R6: clock parked low when no frame is running
  a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
  // R6: rising MDC only happens at mid-bit
  a_r6_rise_mid: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> $past(smp_stb));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        is_wr,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        smp_stb,
  input  logic        end_stb,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        fin,
  output logic        rd_fin,
  output logic [15:0] rd_data
);
  logic [FRAME_BITS-1:0] sh;
  logic [IDX_W-1:0]      idx;
  logic                  wr_q;
  logic [IDX_W-1:0]      nxt;
  logic [FRAME_BITS-1:0] frame_init;

  assign nxt        = idx + 1'b1;
  assign fin        = busy && end_stb && (idx == IDX_W'(FRAME_BITS - 1));
  assign rd_fin     = fin && !wr_q;
  assign frame_init = build_frame(is_wr, phy, regad, wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      idx     <= '0;
      wr_q    <= 1'b0;
      sh      <= '1;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        idx     <= '0;
        wr_q    <= is_wr;
        sh      <= frame_init;
        mdio_o  <= frame_init[FRAME_BITS-1];
        mdio_oe <= 1'b1;
      end
    end else begin
      if (smp_stb && !wr_q && idx >= IDX_W'(DATA_IDX))
        rd_data <= {rd_data[14:0], mdio_i};
      if (fin) begin
        busy    <= 1'b0;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b0;
      end else if (end_stb) begin
        idx     <= nxt;
        sh      <= {sh[FRAME_BITS-2:0], 1'b1};
        mdio_o  <= sh[FRAME_BITS-2];
        mdio_oe <= wr_q || (nxt < IDX_W'(TA_IDX));
      end
    end
  end

  // R4: bus released through turnaround and data of a read
  a_r4_released: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_q && idx >= IDX_W'(TA_IDX)) |-> !mdio_oe);
  // R3: write frames keep the line driven throughout
  a_r3_driven: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_q) |-> mdio_oe);
  // R2: line is driven whenever a frame is running its header
  a_r2_header_driven: assert property (@(posedge clk) disable iff (rst)
    (busy && idx < IDX_W'(TA_IDX)) |-> mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_we,
  input  logic [15:0] cmd_wdata,
  input  logic        dat_we,
  input  logic [15:0] dat_wdata,
  output logic [15:0] dat_rdata,
  output logic        done,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        start;
  logic        busy;
  logic        smp_stb;
  logic        end_stb;
  logic        fin;
  logic        rd_fin;
  logic [15:0] rd_data;
  logic [15:0] dat_q;

  assign start     = cmd_we && done;
  assign dat_rdata = dat_q;

  mdio_clkgen #(.DIV(DIV)) u_clk (
    .clk     (clk),
    .rst     (rst),
    .run     (busy),
    .mdc     (mdc),
    .smp_stb (smp_stb),
    .end_stb (end_stb)
  );

  mdio_frame u_frame (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .is_wr   (cmd_wdata[13]),
    .phy     (cmd_wdata[12:8]),
    .regad   (cmd_wdata[4:0]),
    .wdata   (dat_q),
    .smp_stb (smp_stb),
    .end_stb (end_stb),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .fin     (fin),
    .rd_fin  (rd_fin),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b1;
      dat_q <= '0;
    end else begin
      if (start)    done <= 1'b0;
      else if (fin) done <= 1'b1;
      if (rd_fin)              dat_q <= rd_data;
      else if (dat_we && done) dat_q <= dat_wdata;
    end
  end

  // R7: an accepted command clears the flag on the next edge
  a_r7_done_clears: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && done) |=> !done);
  // R8: data word holds while busy unless a read result lands
  a_r8_data_hold: assert property (@(posedge clk) disable iff (rst)
    (dat_we && !done && !rd_fin) |=> $stable(dat_q));
  // R8: a command during a frame does not end it
  a_r8_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && !done && !fin) |=> !done);
  // R9: reserved command bits never block a start
  a_r9_reserved: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && done && (cmd_wdata[15:14] != 2'b00 || cmd_wdata[7:5] != 3'b000)) |=> busy);
  // R10: output value steady while MDC is high
  a_r10_stable: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_o));
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0;
  logic [15:0] cmd_wdata = '0;
  logic        dat_we = 1'b0;
  logic [15:0] dat_wdata = '0;
  logic [15:0] dat_rdata;
  logic        done, mdc, mdio_o, mdio_oe;
  logic        mdio_i;

  logic        phy_en = 1'b0;
  logic        phy_bit = 1'b1;
  logic [4:0]  resp_addr = 5'd9;
  logic [15:0] resp_val = 16'h0000;
  logic [63:0] obs_line;
  logic [63:0] obs_oe;
  int          rise_cnt = 0;
  int          fall_cnt = 0;
  time         rise_t0, rise_t1;
  int          n_chk = 0;
  int          n_fail = 0;
  int          collide = 0;
  int          cyc = 0;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_master #(.DIV(D)) u_dut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .done(done), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  always @(negedge clk) if (phy_en && mdio_oe) collide++;

  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      obs_line[63-rise_cnt] = mdio_i;
      obs_oe[63-rise_cnt]   = mdio_oe;
      if (rise_cnt == 0) rise_t0 = $time;
      if (rise_cnt == 1) rise_t1 = $time;
      rise_cnt++;
    end
  end

  // Responder: answers reads addressed to resp_addr
  always @(negedge mdc) begin
    fall_cnt++;
    phy_en  = 1'b0;
    phy_bit = 1'b1;
    if (obs_line[63-34] == 1'b1 && obs_line[63-35] == 1'b0 &&
        obs_line[63-36 -: 5] == resp_addr && fall_cnt >= 47 && fall_cnt <= 63) begin
      phy_en  = 1'b1;
      phy_bit = (fall_cnt == 47) ? 1'b0 : resp_val[63-fall_cnt];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] phy,
      input logic [4:0] rg, input logic [15:0] d, input bit present);
    logic [1:0] ta;
    logic [15:0] dv;
    ta = wr ? 2'b10 : (present ? 2'b10 : 2'b11);
    dv = wr ? d : (present ? d : 16'hFFFF);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, ta, dv};
  endfunction

  task automatic wr_data(input logic [15:0] v);
    @(negedge clk); dat_we = 1'b1; dat_wdata = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  // Issue a command; optionally poke registers mid-frame.
  task automatic run_cmd(input logic [15:0] cw, input logic [63:0] ef,
                         input bit wr, input bit poke);
    int n;
    int hi;
    logic [63:0] eoe;
    obs_line = '1; obs_oe = '0; rise_cnt = 0; fall_cnt = 0;
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = cw;
    @(negedge clk); cmd_we = 1'b0;
    check(done == 1'b0, "R7", "done after accept", {63'd0, done}, 64'd0);
    n = 0; hi = 0;
    while (!done && n < 2000) begin
      if (poke && n == 100) begin
        cmd_we = 1'b1; cmd_wdata = cw ^ 16'h3FFF;
        dat_we = 1'b1; dat_wdata = 16'hDEAD;
      end else begin
        cmd_we = 1'b0; dat_we = 1'b0;
      end
      @(negedge clk);
      n++;
      if (mdc) hi++;
    end
    cmd_we = 1'b0; dat_we = 1'b0;
    check(n == 64*D, "R7", "frame cycles", 64'(n), 64'(64*D));
    check(hi == 32*D, "R6", "mdc high cycles", 64'(hi), 64'(32*D));
    check(rise_t1 - rise_t0 == 8*D, "R6", "mdc period ns", 64'(rise_t1 - rise_t0), 64'(8*D));
    check(obs_line == ef, wr ? "R3" : "R2", "frame bits", obs_line, ef);
    eoe = wr ? '1 : {{46{1'b1}}, 18'd0};
    check(obs_oe == eoe, wr ? "R3" : "R4", "oe pattern", obs_oe, eoe);
    @(negedge clk);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R6", "idle mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done && !mdc && !mdio_oe && dat_rdata == 16'h0, "R1", "reset state",
          {45'd0, done, mdc, mdio_oe, dat_rdata}, {45'd0, 1'b1, 1'b0, 1'b0, 16'h0});

    // Write sweep over all PHY addresses; odd ones set reserved bits (R9)
    for (int a = 0; a < 32; a++) begin
      logic [15:0] d;
      logic [15:0] cw;
      logic [4:0]  rg;
      d  = 16'(a * 16'h0841) ^ 16'hA5C3;
      rg = 5'((a * 7) & 31);
      cw = 16'h2000 | (16'(a) << 8) | 16'(rg);
      if (a % 2 == 1) cw = cw | 16'hC0E0;
      wr_data(d);
      run_cmd(cw, exp_frame(1'b1, 5'(a), rg, d, 1'b1), 1'b1, 1'b0);
      check(dat_rdata == d, (a % 2 == 1) ? "R9" : "R3", "data kept after write",
            64'(dat_rdata), 64'(d));
    end

    // Read sweep: only resp_addr answers (R4), others read all ones (R5)
    for (int a = 0; a < 32; a++) begin
      logic [4:0]  rg;
      logic [15:0] ex;
      bit          pr;
      rg = 5'(a ^ 3);
      resp_val = 16'h1234 + 16'(a);
      pr = (5'(a) == resp_addr);
      ex = pr ? resp_val : 16'hFFFF;
      run_cmd((16'(a) << 8) | 16'(rg), exp_frame(1'b0, 5'(a), rg, ex, pr), 1'b0, 1'b0);
      check(dat_rdata == ex, pr ? "R4" : "R5", "read result", 64'(dat_rdata), 64'(ex));
    end

    // Edge data patterns from the present PHY
    for (int k = 0; k < 4; k++) begin
      logic [15:0] v;
      v = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : (k == 2) ? 16'h8001 : 16'h5AA5;
      resp_val = v;
      run_cmd(16'h0900 | 16'(k), exp_frame(1'b0, 5'd9, 5'(k), v, 1'b1), 1'b0, 1'b0);
      check(dat_rdata == v, "R4", "read pattern", 64'(dat_rdata), 64'(v));
    end

    // Writes during a frame are ignored (R8)
    wr_data(16'h6B1E);
    run_cmd(16'h2205, exp_frame(1'b1, 5'd2, 5'd5, 16'h6B1E, 1'b1), 1'b1, 1'b1);
    check(dat_rdata == 16'h6B1E, "R8", "data word during busy", 64'(dat_rdata), 64'h6B1E);
    resp_val = 16'hC3A0;
    run_cmd(16'h091F, exp_frame(1'b0, 5'd9, 5'd31, 16'hC3A0, 1'b1), 1'b0, 1'b1);
    check(dat_rdata == 16'hC3A0, "R8", "read result after busy pokes", 64'(dat_rdata), 64'hC3A0);

    check(collide == 0, "R4", "bus contention cycles", 64'(collide), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule